// File: doc/BRIEF.md
# Configurable Programmable I/O Cell

This block is the per-pin I/O cell of a programmable logic fabric. It sits between one pad and the fabric. Data from the fabric travels to the pad through the output path. Data from the pad travels back to one dedicated fabric track through the input path. The cell has a single data flip-flop. Static configuration bits give that flip-flop to the output path or to the input path, or leave both paths combinational.

The pad drive enable comes from an eight-way selector. Its choices are four global control lines, two output-control-channel lines, a constant "drive" and a constant "high impedance". A dedicated enable register follows the selector, and a configuration bit can bypass it. Asking for both paths to be registered is an illegal setting. In that case the cell raises an error flag and registers only the output. The slew-rate and bus-hold bits are analog pad settings, so the cell only passes them through to status outputs.

Configuration inputs are meant to be static. The cell still responds correctly, cycle by cycle, when they change.

Top module: `pio_cell`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the data flip-flop and the enable register to 0. In the cycle after reset, a registered path therefore presents 0, and `pad_oe` is 0 whenever `cfg_oe_bypass` is 0.
- R2: With `cfg_out_reg` = 0, `pad_out` equals `fab_dout` in the same cycle.
- R3: With `cfg_out_reg` = 1, `pad_out` shows the `fab_dout` value that was sampled at the previous rising edge.
- R4: When the input path is not registered, `fab_din` equals `pad_in` in the same cycle. This holds whenever `cfg_in_reg` = 0 or `cfg_out_reg` = 1.
- R5: With `cfg_in_reg` = 1 and `cfg_out_reg` = 0, `fab_din` shows the `pad_in` value that was sampled at the previous rising edge.
- R6: With `cfg_in_reg` = 1 and `cfg_out_reg` = 1, `cfg_err` is 1, the output is registered as in R3, and the input is combinational as in R4. Otherwise `cfg_err` is 0.
- R7: The enable select code `cfg_oe_sel` works as follows:
  - codes 0 to 3 pick `glb_ctl[code]`;
  - codes 4 and 5 pick `occ_ctl[code-4]`;
  - code 6 gives a constant 1 (drive);
  - code 7 gives a constant 0 (high impedance).
- R8: With `cfg_oe_bypass` = 0, `pad_oe` equals the selected enable value at the previous rising edge.
- R9: With `cfg_oe_bypass` = 1, `pad_oe` equals the selected enable value in the same cycle.
- R10: `stat_slew` equals `cfg_slew`, and `stat_hold` equals `cfg_hold`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_reg | input | 1 | Ask for a registered input path |
| cfg_out_reg | input | 1 | Ask for a registered output path |
| cfg_oe_sel | input | 3 | Enable source select code (R7) |
| cfg_oe_bypass | input | 1 | Skip the enable register |
| cfg_slew | input | 1 | Slow-slew setting, passed through |
| cfg_hold | input | 1 | Bus-hold setting, passed through |
| fab_dout | input | 1 | Output data from the fabric |
| glb_ctl | input | 4 | Global control lines |
| occ_ctl | input | 2 | Output-control-channel lines |
| pad_in | input | 1 | Value seen at the pad |
| fab_din | output | 1 | Input data to the fabric track |
| pad_out | output | 1 | Data driven toward the pad |
| pad_oe | output | 1 | Pad drive enable (1 = drive) |
| cfg_err | output | 1 | Illegal both-registered setting |
| stat_slew | output | 1 | Copy of cfg_slew |
| stat_hold | output | 1 | Copy of cfg_hold |

## Verification
Two functions can act in the same cycle. One is the fallback for an illegal both-registered setting, which hands the shared flip-flop to the output path. The other is the registered input path, which wants that same flip-flop. The bench sets both register requests at once, in directed cases and in random ones, and judges the result against a bench model: `pad_out` must lag `fab_dout` by one edge, and `fab_din` must track `pad_in` in the same cycle. In the same cycles the enable register is loaded from a randomly chosen source, so the enable path and the data path are both judged under one shared clock edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned N_GLB = 4;
  localparam int unsigned N_OCC = 2;
  localparam int unsigned N_SRC = N_GLB + N_OCC + 2;
  localparam int unsigned SEL_W = $clog2(N_SRC);
  localparam logic [SEL_W-1:0] SEL_DRIVE = SEL_W'(N_GLB + N_OCC);
  localparam logic [SEL_W-1:0] SEL_HIZ   = SEL_W'(N_GLB + N_OCC + 1);

  typedef enum logic [1:0] {
    FF_NONE = 2'd0,
    FF_IN   = 2'd1,
    FF_OUT  = 2'd2
  } ff_owner_e;
endpackage

// File: rtl/pio_oe_pick.sv
module pio_oe_pick
  import pio_pkg::*;
#(
  parameter int unsigned NG = N_GLB,
  parameter int unsigned NO = N_OCC,
  parameter int unsigned SW = SEL_W
) (
  input  logic [SW-1:0] sel,
  input  logic [NG-1:0] glb,
  input  logic [NO-1:0] occ,
  output logic          oe_pick
);
  localparam int unsigned NPAD = 1 << SW;
  logic [NPAD-1:0] src;

  genvar i;
  generate
    for (i = 0; i < NPAD; i++) begin : g_src
      if (i < NG) begin : g_glb
        assign src[i] = glb[i];
      end else if (i < NG + NO) begin : g_occ
        assign src[i] = occ[i-NG];
      end else if (i == NG + NO) begin : g_drv
        assign src[i] = 1'b1;
      end else begin : g_off
        assign src[i] = 1'b0;
      end
    end
  endgenerate

  assign oe_pick = src[sel];
endmodule

// File: rtl/pio_oe_stage.sv
module pio_oe_stage (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic oe_pick,
  output logic pad_oe
);
  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= oe_pick;
  end

  assign pad_oe = bypass ? oe_pick : oe_q;
endmodule

// File: rtl/pio_data_path.sv
module pio_data_path
  import pio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic want_in_reg,
  input  logic want_out_reg,
  input  logic fab_dout,
  input  logic pad_in,
  output logic pad_out,
  output logic fab_din,
  output logic bad_cfg
);
  ff_owner_e owner;
  logic      ff_d;
  logic      ff_q;

  always_comb begin
    if (want_out_reg)     owner = FF_OUT;
    else if (want_in_reg) owner = FF_IN;
    else                  owner = FF_NONE;
  end

  assign ff_d = (owner == FF_OUT) ? fab_dout : pad_in;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= 1'b0;
    else     ff_q <= ff_d;
  end

  assign pad_out = (owner == FF_OUT) ? ff_q : fab_dout;
  assign fab_din = (owner == FF_IN)  ? ff_q : pad_in;
  assign bad_cfg = want_in_reg & want_out_reg;
endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_in_reg,
  input  logic             cfg_out_reg,
  input  logic [SEL_W-1:0] cfg_oe_sel,
  input  logic             cfg_oe_bypass,
  input  logic             cfg_slew,
  input  logic             cfg_hold,
  input  logic             fab_dout,
  input  logic [N_GLB-1:0] glb_ctl,
  input  logic [N_OCC-1:0] occ_ctl,
  input  logic             pad_in,
  output logic             fab_din,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             cfg_err,
  output logic             stat_slew,
  output logic             stat_hold
);
  logic oe_pick;

  pio_data_path u_data (
    .clk          (clk),
    .rst          (rst),
    .want_in_reg  (cfg_in_reg),
    .want_out_reg (cfg_out_reg),
    .fab_dout     (fab_dout),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .fab_din      (fab_din),
    .bad_cfg      (cfg_err)
  );

  pio_oe_pick #(.NG(N_GLB), .NO(N_OCC), .SW(SEL_W)) u_pick (
    .sel     (cfg_oe_sel),
    .glb     (glb_ctl),
    .occ     (occ_ctl),
    .oe_pick (oe_pick)
  );

  pio_oe_stage u_oe (
    .clk     (clk),
    .rst     (rst),
    .bypass  (cfg_oe_bypass),
    .oe_pick (oe_pick),
    .pad_oe  (pad_oe)
  );

  assign stat_slew = cfg_slew;
  assign stat_hold = cfg_hold;
endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk
  import pio_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_in_reg,
  input logic             cfg_out_reg,
  input logic [SEL_W-1:0] cfg_oe_sel,
  input logic             cfg_oe_bypass,
  input logic             fab_dout,
  input logic             pad_in,
  input logic             fab_din,
  input logic             pad_out,
  input logic             pad_oe,
  input logic             cfg_err,
  input logic             oe_pick
);
  logic armed;
  logic after_rst;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
    after_rst <= rst;
  end

  // R1: the enable register reads 0 right after reset
  p_rst_oe_clear_r1: assert property (@(posedge clk)
    (armed && after_rst && !rst && !cfg_oe_bypass) |-> !pad_oe);

  // R3: a registered output lags the fabric data by one edge
  p_out_lag_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !after_rst && cfg_out_reg && $past(cfg_out_reg)) |-> pad_out == $past(fab_dout));

  // R5: a registered input lags the pad by one edge
  p_in_lag_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && !after_rst && cfg_in_reg && !cfg_out_reg && $past(cfg_in_reg) && !$past(cfg_out_reg))
      |-> fab_din == $past(pad_in));

  // R6: an illegal setting keeps the input combinational
  p_err_in_comb_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && cfg_err) |-> fab_din == pad_in);

  // R7: the constant-drive code enables the pad when the register is skipped
  p_const_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && cfg_oe_bypass && cfg_oe_sel == SEL_DRIVE) |-> pad_oe);

  // R8: the enable register lags the selected source by one edge
  p_oe_lag_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && !after_rst && !cfg_oe_bypass) |-> pad_oe == $past(oe_pick));
endmodule

bind pio_cell pio_cell_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_in_reg    (cfg_in_reg),
  .cfg_out_reg   (cfg_out_reg),
  .cfg_oe_sel    (cfg_oe_sel),
  .cfg_oe_bypass (cfg_oe_bypass),
  .fab_dout      (fab_dout),
  .pad_in        (pad_in),
  .fab_din       (fab_din),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .cfg_err       (cfg_err),
  .oe_pick       (oe_pick)
);

// File: tb/sim_pio_cell.sv
`timescale 1ns/1ps
module sim_pio_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_in_reg = 0, cfg_out_reg = 0, cfg_oe_bypass = 0, cfg_slew = 0, cfg_hold = 0;
  logic [2:0] cfg_oe_sel = 3'd7;
  logic       fab_dout = 0, pad_in = 0;
  logic [3:0] glb_ctl = 0;
  logic [1:0] occ_ctl = 0;
  logic       fab_din, pad_out, pad_oe, cfg_err, stat_slew, stat_hold;

  int n_chk = 0;
  int n_bad = 0;
  logic m_ff = 0;
  logic m_oe = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  pio_cell u0 (
    .clk(clk), .rst(rst), .cfg_in_reg(cfg_in_reg), .cfg_out_reg(cfg_out_reg),
    .cfg_oe_sel(cfg_oe_sel), .cfg_oe_bypass(cfg_oe_bypass), .cfg_slew(cfg_slew),
    .cfg_hold(cfg_hold), .fab_dout(fab_dout), .glb_ctl(glb_ctl), .occ_ctl(occ_ctl),
    .pad_in(pad_in), .fab_din(fab_din), .pad_out(pad_out), .pad_oe(pad_oe),
    .cfg_err(cfg_err), .stat_slew(stat_slew), .stat_hold(stat_hold)
  );

  // R7 reference selector
  function automatic logic exp_pick(input logic [2:0] s, input logic [3:0] g, input logic [1:0] o);
    if (s < 3'd4)       return g[s[1:0]];
    else if (s < 3'd6)  return o[s[0]];
    else if (s == 3'd6) return 1'b1;
    else                return 1'b0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, mid low phase
  task automatic check_all();
    logic out_ff, in_ff, e_out, e_in, e_oe, pk;
    out_ff = cfg_out_reg;
    in_ff  = cfg_in_reg & ~cfg_out_reg;
    e_out  = out_ff ? m_ff : fab_dout;
    e_in   = in_ff ? m_ff : pad_in;
    pk     = exp_pick(cfg_oe_sel, glb_ctl, occ_ctl);
    e_oe   = cfg_oe_bypass ? pk : m_oe;
    chk(out_ff ? "R3 pad_out registered" : "R2 pad_out comb", pad_out, e_out);
    chk(in_ff ? "R5 fab_din registered" : "R4 fab_din comb", fab_din, e_in);
    chk(cfg_oe_bypass ? "R9/R7 pad_oe bypass" : "R8 pad_oe registered", pad_oe, e_oe);
    chk("R6 cfg_err", cfg_err, cfg_in_reg & cfg_out_reg);
    chk("R10 stat_slew", stat_slew, cfg_slew);
    chk("R10 stat_hold", stat_hold, cfg_hold);
  endtask

  // advance one edge, updating the model from inputs held across it
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      m_ff = 0;
      m_oe = 0;
    end else begin
      m_ff = cfg_out_reg ? fab_dout : pad_in;
      m_oe = exp_pick(cfg_oe_sel, glb_ctl, occ_ctl);
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    rst = 1;
    cfg_in_reg = 1; cfg_out_reg = 0; cfg_oe_bypass = 0; fab_dout = 1; pad_in = 1;
    glb_ctl = 4'hF; cfg_oe_sel = 3'd0;
    tick();
    tick();
    rst = 0;
    #1;
    // R1: right after reset, registered input reads 0, enable register reads 0
    chk("R1 fab_din after reset", fab_din, 1'b0);
    chk("R1 pad_oe after reset", pad_oe, 1'b0);
    cfg_in_reg = 0; cfg_out_reg = 1; #1;
    chk("R1 pad_out after reset", pad_out, 1'b0);

    // R6: both registered requested
    cfg_in_reg = 1; cfg_out_reg = 1; fab_dout = 1; pad_in = 0; #1;
    check_all();
    tick();
    fab_dout = 0; pad_in = 1; #1;
    chk("R6 fallback output registered", pad_out, 1'b1);
    chk("R6 fallback input comb", fab_din, 1'b1);
    chk("R6 error flag", cfg_err, 1'b1);
    tick();
    #1 check_all();

    // R7/R9: every select code with the register skipped
    cfg_oe_bypass = 1; glb_ctl = 4'b1010; occ_ctl = 2'b01;
    for (int s = 0; s < 8; s++) begin
      cfg_oe_sel = 3'(s); #1;
      chk("R7 select code", pad_oe, exp_pick(3'(s), glb_ctl, occ_ctl));
      tick();
    end
    glb_ctl = 4'b0101; occ_ctl = 2'b10;
    for (int s = 0; s < 8; s++) begin
      cfg_oe_sel = 3'(s); #1;
      chk("R7 select code inverted", pad_oe, exp_pick(3'(s), glb_ctl, occ_ctl));
      tick();
    end

    // random traffic with occasional reset and config changes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      rst           = (r[4:0] == 5'd0);
      cfg_in_reg    = r[5];
      cfg_out_reg   = r[6];
      cfg_oe_sel    = r[9:7];
      cfg_oe_bypass = r[10];
      cfg_slew      = r[11];
      cfg_hold      = r[12];
      fab_dout      = r[13];
      pad_in        = r[14];
      glb_ctl       = r[18:15];
      occ_ctl       = r[20:19];
      #1 check_all();
      tick();
    end
    rst = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule